// File: doc/BRIEF.md
# Dual-Speed Bus Cycle Timing Generator

This block runs from a single base clock and produces the cycle timing for two sides of a bus. The fast processor side gets a strobe once per five-clock cycle. A refresh window of five clocks repeats every fifty clocks. The slow compatibility side gets a strobe at the end of each of its cycles. A slow cycle normally lasts fourteen base clocks, but the last of every sixty-five is stretched to sixteen, so a horizontal line takes 912 base clocks. Because of that stretch, the slow side drifts against the fast side. The two come back into phase after 25 lines, which is 22800 clocks, and the block marks that clock with a one-clock realignment pulse.

From the slow-side position, the block also reports which horizontal region the current slow cycle lies in. Within a line, the region sequence runs: a right border, then horizontal blank, then a left border, then active video.

A fast-side requester presents an access with a target class and holds it while the stall output is high. Accesses to low-bank RAM wait out the refresh window. I/O accesses in the first two banks, and the unpenalised class, are never held. Accesses aimed at the slow side wait for the next slow-cycle boundary and then occupy the whole slow cycle that follows it. The clock in which stall is low is the clock in which the access completes.

Top module: `dual_speed_timing`

## Requirements
- R1: `fast_stb` is high in exactly one clock of every 5. Counting the first clock after reset release as index 0, it is high at indices 4, 9, 14, and so on.
- R2: `refresh_active` is high in clocks 45 to 49 of every 50-clock period, counted from reset release. It is low in all other clocks.
- R3: When `req_valid` is low, `stall` is low. For class 0 (low-bank RAM), `stall` equals `refresh_active` in every clock. For class 1 (low-bank I/O) and class 3 (unpenalised), `stall` is always low.
- R4: `slow_stb` marks the last clock of each slow cycle. Slow cycles 0 to 63 of a line last 14 clocks each, and slow cycle 64 lasts 16 clocks, for 912 clocks per line.
- R5: `hregion` gives the region of the current slow cycle within its line: 0 for right border (slow cycles 0 to 5), 1 for horizontal blank (6 to 18), 2 for left border (19 to 24), and 3 for active video (25 to 64).
- R6: `realign` is high for one clock every 22800 clocks, at index 22799 modulo 22800. That clock ends line 24 and carries both `fast_stb` and `slow_stb`.
- R7: A class 2 (slow-side) request held from clock k keeps `stall` high from clock k onward. `stall` first goes low in the last clock of the slow cycle that follows the slow cycle containing k. Clock k counts as part of its own slow cycle even when k is that cycle's last clock.
- R8: Reset is synchronous and active-low. While reset is applied, and in index 0 after release, the outputs show the first clock of a right-border slow cycle: every strobe is low, `refresh_active` is low, `hregion` is 0, and no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fast-side access present, held while stall is high |
| req_class | input | 2 | Target class: 0 low RAM, 1 low I/O, 2 slow side, 3 unpenalised |
| fast_stb | output | 1 | Last clock of a fast cycle |
| slow_stb | output | 1 | Last clock of a slow cycle |
| refresh_active | output | 1 | Refresh window in progress |
| stall | output | 1 | Present access must wait this clock |
| hregion | output | 2 | Horizontal region of the current slow cycle |
| realign | output | 1 | Fast and slow sides back in phase |

## Verification
Every output is valid in the same clock as the counter state that produces it. Strobes, region and realignment depend only on registers, so the value at index k follows directly from k. `stall` responds combinationally to the request presented in that same clock. The bench drives inputs on the falling edge and samples one nanosecond later, then compares against a model indexed by the number of rising edges since reset release. For slow-side accesses, it counts the stalled clocks from the request to the clock where stall drops and compares that count with the length computed from the slow-cycle schedule.

// File: rtl/tgen_pkg.sv
// Package: shared types for the dual-speed timing generator.
// Assumes: two-bit region and access class codes, as fixed at the top ports.
package tgen_pkg;

    // Horizontal region of the current slow cycle, in line order.
    typedef enum logic [1:0] {
        REG_RBORDER = 2'd0,
        REG_HBLANK  = 2'd1,
        REG_LBORDER = 2'd2,
        REG_ACTIVE  = 2'd3
    } hregion_e;

    // Target class of a fast-side access.
    typedef enum logic [1:0] {
        ACC_LOWRAM = 2'd0,
        ACC_LOWIO  = 2'd1,
        ACC_SLOW   = 2'd2,
        ACC_UNPEN  = 2'd3
    } acc_class_e;

    // Progress of a slow-side access.
    typedef enum logic [1:0] {
        SY_IDLE = 2'd0,
        SY_WAIT = 2'd1,
        SY_BUSY = 2'd2
    } sync_state_e;

endpackage

// File: rtl/tgen_fast_seq.sv
// Module: fast-side cycle counter and refresh window generator.
// Does: strobes the last base clock of each fast cycle and raises the refresh
//       flag in the last REF_LEN clocks of every REF_PERIOD-clock period.
// Assumes: REF_LEN < REF_PERIOD; both counters start at zero after reset.
module tgen_fast_seq #(
    parameter int unsigned FAST_DIV   = 5,
    parameter int unsigned REF_PERIOD = 50,
    parameter int unsigned REF_LEN    = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_stb,
    output logic refresh_active
);
    localparam int unsigned FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam int unsigned RW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;
    localparam int unsigned REF_START = REF_PERIOD - REF_LEN;

    logic [FW-1:0] fast_cnt_q;

    // Fast cycle position, wrapping at FAST_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_cnt_q <= '0;
        end else if (fast_cnt_q == FW'(FAST_DIV - 1)) begin
            fast_cnt_q <= '0;
        end else begin
            fast_cnt_q <= fast_cnt_q + 1'b1;
        end
    end

    assign fast_stb = (fast_cnt_q == FW'(FAST_DIV - 1));

    generate
        if (REF_LEN == 0) begin : g_no_refresh
            assign refresh_active = 1'b0;
        end else begin : g_refresh
            logic [RW-1:0] ref_cnt_q;

            // Position within the refresh period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ref_cnt_q <= '0;
                end else if (ref_cnt_q == RW'(REF_PERIOD - 1)) begin
                    ref_cnt_q <= '0;
                end else begin
                    ref_cnt_q <= ref_cnt_q + 1'b1;
                end
            end

            assign refresh_active = (ref_cnt_q >= RW'(REF_START));
        end
    endgenerate

endmodule

// File: rtl/tgen_slow_seq.sv
// Module: slow-side cycle, horizontal slot and line counter.
// Does: counts SLOW_DIV clocks per slow cycle, stretching the last slot of a
//       line to SLOW_LONG_DIV; tracks the slot within the line and the line
//       within the realignment frame, and flags the frame's final clock.
// Assumes: the chosen lengths make the frame a multiple of the fast cycle.
module tgen_slow_seq #(
    parameter int unsigned SLOW_DIV      = 14,
    parameter int unsigned SLOW_LONG_DIV = 16,
    parameter int unsigned SLOTS         = 65,
    parameter int unsigned LINES         = 25,
    localparam int unsigned HW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          slow_stb,
    output logic [HW-1:0] hpos,
    output logic          realign
);
    localparam int unsigned MAXD = (SLOW_LONG_DIV > SLOW_DIV) ? SLOW_LONG_DIV : SLOW_DIV;
    localparam int unsigned CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam int unsigned LW   = (LINES > 1) ? $clog2(LINES) : 1;

    logic [CW-1:0] cnt_q;
    logic [HW-1:0] hpos_q;
    logic [LW-1:0] line_q;
    logic          last_slot;
    logic          last_line;
    logic [CW-1:0] term;

    // Terminal count of the current slow cycle, long in the final slot.
    always_comb begin
        last_slot = (hpos_q == HW'(SLOTS - 1));
        last_line = (line_q == LW'(LINES - 1));
        term      = last_slot ? CW'(SLOW_LONG_DIV - 1) : CW'(SLOW_DIV - 1);
        slow_stb  = (cnt_q == term);
    end

    // Advance clock, slot and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hpos_q <= '0;
            line_q <= '0;
        end else if (slow_stb) begin
            cnt_q <= '0;
            if (last_slot) begin
                hpos_q <= '0;
                line_q <= last_line ? '0 : line_q + 1'b1;
            end else begin
                hpos_q <= hpos_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hpos    = hpos_q;
    assign realign = slow_stb && last_slot && last_line;

endmodule

// File: rtl/tgen_region_dec.sv
// Module: horizontal region decoder.
// Does: maps a slot number within the line onto right border, blank,
//       left border or active video, in that order.
// Assumes: slots past the three leading regions are all active video.
module tgen_region_dec
    import tgen_pkg::*;
#(
    parameter int unsigned HW      = 7,
    parameter int unsigned RB_LEN  = 6,
    parameter int unsigned HB_LEN  = 13,
    parameter int unsigned LB_LEN  = 6
) (
    input  logic [HW-1:0] hpos,
    output hregion_e      region
);
    localparam int unsigned HB_START  = RB_LEN;
    localparam int unsigned LB_START  = RB_LEN + HB_LEN;
    localparam int unsigned ACT_START = RB_LEN + HB_LEN + LB_LEN;

    // Compare the slot against the region boundaries.
    always_comb begin
        if (hpos < HW'(HB_START)) begin
            region = REG_RBORDER;
        end else if (hpos < HW'(LB_START)) begin
            region = REG_HBLANK;
        end else if (hpos < HW'(ACT_START)) begin
            region = REG_LBORDER;
        end else begin
            region = REG_ACTIVE;
        end
    end

endmodule

// File: rtl/tgen_access_ctl.sv
// Module: access stall control.
// Does: holds low-RAM accesses during refresh; makes slow-side accesses wait
//       for the next slow boundary and then span one whole slow cycle.
// Assumes: the requester keeps req_valid and req_class steady while stall is
//          high and drops or changes the request after the completing clock.
module tgen_access_ctl
    import tgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  acc_class_e req_class,
    input  logic       refresh_active,
    input  logic       slow_stb,
    output logic       stall
);
    sync_state_e st_q, st_d;
    logic        slow_req;

    assign slow_req = req_valid && (req_class == ACC_SLOW);

    // Next state and stall for the access presented this clock.
    always_comb begin
        st_d  = st_q;
        stall = 1'b0;
        case (st_q)
            SY_IDLE: begin
                if (slow_req) begin
                    stall = 1'b1;
                    st_d  = slow_stb ? SY_BUSY : SY_WAIT;
                end else if (req_valid && (req_class == ACC_LOWRAM)) begin
                    stall = refresh_active;
                end
            end
            SY_WAIT: begin
                stall = 1'b1;
                if (slow_stb) st_d = SY_BUSY;
            end
            SY_BUSY: begin
                stall = !slow_stb;
                if (slow_stb) st_d = SY_IDLE;
            end
            default: st_d = SY_IDLE;
        endcase
    end

    // Slow-access progress register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SY_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dual_speed_timing.sv
// Module: dual-speed bus cycle timing generator (top).
// Does: combines the fast sequencer, slow sequencer, region decoder and
//       access stall control behind one set of ports.
// Assumes: a single base clock; all sequencers reset together.
module dual_speed_timing
    import tgen_pkg::*;
#(
    parameter int unsigned FAST_DIV      = 5,
    parameter int unsigned REF_PERIOD    = 50,
    parameter int unsigned REF_LEN       = 5,
    parameter int unsigned SLOW_DIV      = 14,
    parameter int unsigned SLOW_LONG_DIV = 16,
    parameter int unsigned SLOTS         = 65,
    parameter int unsigned LINES         = 25,
    parameter int unsigned RB_LEN        = 6,
    parameter int unsigned HB_LEN        = 13,
    parameter int unsigned LB_LEN        = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_class,
    output logic       fast_stb,
    output logic       slow_stb,
    output logic       refresh_active,
    output logic       stall,
    output logic [1:0] hregion,
    output logic       realign
);
    localparam int unsigned HW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [HW-1:0] hpos;
    hregion_e      region;
    acc_class_e    cls;

    assign cls = acc_class_e'(req_class);

    tgen_fast_seq #(
        .FAST_DIV  (FAST_DIV),
        .REF_PERIOD(REF_PERIOD),
        .REF_LEN   (REF_LEN)
    ) u_fast (
        .clk           (clk),
        .rst_n         (rst_n),
        .fast_stb      (fast_stb),
        .refresh_active(refresh_active)
    );

    tgen_slow_seq #(
        .SLOW_DIV     (SLOW_DIV),
        .SLOW_LONG_DIV(SLOW_LONG_DIV),
        .SLOTS        (SLOTS),
        .LINES        (LINES)
    ) u_slow (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_stb(slow_stb),
        .hpos    (hpos),
        .realign (realign)
    );

    tgen_region_dec #(
        .HW    (HW),
        .RB_LEN(RB_LEN),
        .HB_LEN(HB_LEN),
        .LB_LEN(LB_LEN)
    ) u_region (
        .hpos  (hpos),
        .region(region)
    );

    tgen_access_ctl u_access (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_class     (cls),
        .refresh_active(refresh_active),
        .slow_stb      (slow_stb),
        .stall         (stall)
    );

    assign hregion = region;

endmodule

// File: rtl/dual_speed_timing_chk.sv
// Module: property checker for the dual-speed timing generator.
// Does: watches the top-level ports and flags timing relations that break.
// Assumes: attached with the bind below; observes ports only.
module dual_speed_timing_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_class,
    input logic       fast_stb,
    input logic       slow_stb,
    input logic       refresh_active,
    input logic       stall,
    input logic [1:0] hregion,
    input logic       realign
);
    // R1: a fast strobe never repeats on the following clock.
    p_fast_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fast_stb |=> !fast_stb);

    // R2: a refresh window always ends on a fast-cycle boundary.
    p_refresh_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_active) |-> $past(fast_stb));

    // R3: low-RAM accesses wait exactly while refresh runs.
    p_lowram_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 2'd0) |-> (stall == refresh_active));

    // R3: low-I/O accesses and idle clocks are never held.
    p_no_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_class == 2'd1) |-> !stall);

    // R4: a slow strobe never repeats on the following clock.
    p_slow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_stb |=> !slow_stb);

    // R5: the region only moves after a slow-cycle boundary.
    p_region_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_stb |=> $stable(hregion));

    // R5: active video is followed by the right border of the next line.
    p_region_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_stb && hregion == 2'd3) |=> (hregion != 2'd1 && hregion != 2'd2));

    // R6: realignment coincides with both strobes at the end of active video.
    p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> (fast_stb && slow_stb && hregion == 2'd3));

    // R7: a slow-side access only completes on a slow strobe.
    p_slow_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 2'd2 && !stall) |-> slow_stb);

endmodule

bind dual_speed_timing dual_speed_timing_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_class     (req_class),
    .fast_stb      (fast_stb),
    .slow_stb      (slow_stb),
    .refresh_active(refresh_active),
    .stall         (stall),
    .hregion       (hregion),
    .realign       (realign)
);

// File: tb/test_dual_speed_timing.sv
// Bench: scoreboard for the dual-speed timing generator.
// A driver pushes expected outputs for each clock into a queue; the monitor
// pops them and compares against the ports one nanosecond after the falling edge.
module test_dual_speed_timing;

    localparam int unsigned LINE_CLK  = 912;
    localparam int unsigned SHORT_END = 896;
    localparam int unsigned FRAME_CLK = 22800;

    typedef struct {
        logic       fs;
        logic       ss;
        logic       rf;
        logic       rl;
        logic [1:0] rg;
        logic       st;
        bit         chk_st;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = 2'd0;
    logic       fast_stb, slow_stb, refresh_active, stall, realign;
    logic [1:0] hregion;

    int unsigned k = 0;
    int          n_checks = 0;
    int          n_fails = 0;
    logic        last_stall;
    exp_t        exp_q[$];

    dual_speed_timing i_dual_speed_timing (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_class     (req_class),
        .fast_stb      (fast_stb),
        .slow_stb      (slow_stb),
        .refresh_active(refresh_active),
        .stall         (stall),
        .hregion       (hregion),
        .realign       (realign)
    );

    always #5 clk = ~clk;

    function automatic logic m_slow_stb(int unsigned idx);
        int unsigned p = idx % LINE_CLK;
        if (p < SHORT_END) return (p % 14) == 13;
        return p == LINE_CLK - 1;
    endfunction

    function automatic logic [1:0] m_region(int unsigned idx);
        int unsigned p = idx % LINE_CLK;
        int unsigned h = (p < SHORT_END) ? p / 14 : 64;
        if (h < 6)  return 2'd0;
        if (h < 19) return 2'd1;
        if (h < 25) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s at index %0d: actual %b expected %b", tag, k, act, expv);
        end
    endtask

    // Driver: expected outputs for index k under the given request.
    task automatic push_expect(input logic v, input logic [1:0] c);
        exp_t e;
        e.fs = (k % 5) == 4;
        e.rf = (k % 50) >= 45;
        e.ss = m_slow_stb(k);
        e.rg = m_region(k);
        e.rl = (k % FRAME_CLK) == FRAME_CLK - 1;
        e.chk_st = !(v && c == 2'd2);
        e.st = (v && c == 2'd0) ? e.rf : 1'b0;
        exp_q.push_back(e);
    endtask

    // Monitor: pop one expected item and compare every output.
    task automatic monitor();
        exp_t e = exp_q.pop_front();
        check("R1 fast_stb", fast_stb, e.fs);
        check("R2 refresh_active", refresh_active, e.rf);
        check("R4 slow_stb", slow_stb, e.ss);
        check("R6 realign", realign, e.rl);
        n_checks++;
        if (hregion !== e.rg) begin
            n_fails++;
            $display("FAIL R5 hregion at index %0d: actual %0d expected %0d", k, hregion, e.rg);
        end
        if (e.chk_st) check("R3 stall", stall, e.st);
    endtask

    // One clock: drive at the falling edge, sample 1 ns later, advance.
    task automatic step(input logic v, input logic [1:0] c);
        req_valid = v;
        req_class = c;
        push_expect(v, c);
        #1;
        monitor();
        last_stall = stall;
        @(negedge clk);
        k++;
    endtask

    task automatic check_reset_state();
        check("R8 fast_stb", fast_stb, 1'b0);
        check("R8 slow_stb", slow_stb, 1'b0);
        check("R8 refresh_active", refresh_active, 1'b0);
        check("R8 realign", realign, 1'b0);
        check("R8 stall", stall, 1'b0);
        check("R8 hregion0", hregion[0], 1'b0);
        check("R8 hregion1", hregion[1], 1'b0);
    endtask

    task automatic apply_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
    endtask

    // R7: hold a slow request from line position p and measure the stall.
    task automatic slow_case(input int unsigned p);
        int unsigned e1, done_at, exp_len, n;
        bit finished;
        while ((k % LINE_CLK) != p) step(1'b0, 2'd0);
        e1 = k;
        while (!m_slow_stb(e1)) e1++;
        done_at = e1 + 1;
        while (!m_slow_stb(done_at)) done_at++;
        exp_len = done_at - k;
        n = 0;
        finished = 0;
        for (int i = 0; i < 64 && !finished; i++) begin
            step(1'b1, 2'd2);
            if (last_stall) n++;
            else finished = 1;
        end
        n_checks++;
        if (!finished || n != exp_len) begin
            n_fails++;
            $display("FAIL R7 slow stall from position %0d: actual %0d expected %0d", p, n, exp_len);
        end
        step(1'b0, 2'd0);
    endtask

    initial begin
        #(10 * 150000);
        n_fails++;
        $display("FAIL watchdog expired at index %0d: actual running expected done", k);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset();
        // Full realignment frame with low-RAM, low-I/O and unpenalised requests (R3).
        for (int i = 0; i < 22830; i++) begin
            if (k >= 90 && k < 160)       step(1'b1, 2'd0);
            else if (k >= 160 && k < 230) step(1'b1, 2'd1);
            else if (k >= 230 && k < 300) step(1'b1, 2'd3);
            else                          step(1'b0, 2'd0);
        end
        // Slow-side accesses at cycle start, mid-cycle, on a boundary,
        // before the stretched slot and inside it (R7).
        slow_case(0);
        slow_case(5);
        slow_case(13);
        slow_case(885);
        slow_case(900);
        slow_case(895);
        // Reset in mid-run returns to the start state (R8).
        for (int i = 0; i < 17; i++) step(1'b0, 2'd0);
        apply_reset();
        for (int i = 0; i < 120; i++) step(1'b0, 2'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule